// File: doc/BRIEF.md
# Serial Command Decoder and Scan Sequencer

This block accepts 8-bit command bytes on a serial input framed by an active-low chip select. A leading one-hot prefix marks each byte as one of four commands: conversion, setup, averaging or reset. Setup and averaging bytes update configuration registers. A reset byte clears either every setting or only the downstream result buffer.

A conversion byte starts a scan. The sequencer walks a channel list with a level request and one-cycle acknowledge handshake on a converter port. It sums the samples that make up each result, scales the sum down by the averaging count, and pushes one result per channel step into an external result buffer. When the selected reference is internal and not yet powered, the sequencer first waits a fixed wake-up interval. A conversion byte that arrives while a scan is running is dropped, and the busy output shows when a scan is running.

Top module: `cmd_scan_ctrl`

## Requirements
- R1: Bits are taken most significant first on each rising serial clock edge while chip select is low. A byte is complete after eight edges. Raising chip select discards a partial byte.
- R2: A byte of the form 01xxxxxx is a setup command. Bits 5:4 go to the clock-mode output and bits 3:2 go to the reference-select output.
- R3: A byte of the form 001xxxxx is an averaging command. Bit 4 enables averaging, bits 3:2 are the count code and bits 1:0 are the repeat-count code. These settings take effect at the next scan.
- R4: With averaging on, count codes 00, 01, 10 and 11 give 4, 8, 16 and 32 samples per result. The result is the sum shifted right by 2, 3, 4 or 5. With averaging off, each result is one sample.
- R5: A byte of the form 1cccc mm x is a conversion command, with channel c in bits 6:3 and mode m in bits 2:1. Mode 00 scans channel 0 up to c. Mode 01 scans c up to 15. Mode 10 repeats c for 4×(repeat code+1) results. Mode 11 converts c once. Bit 0 has no effect.
- R6: The reference select decides the wake-up wait. With code 00 the first sample request comes REF_WAKE cycles after busy rises, on every scan. With code 01 it comes in the same cycle busy rises. With codes 10 and 11 the wait happens only on the first scan after the setup write, because the reference then stays powered.
- R7: Busy is high from the accepted conversion until the last result is pushed. A conversion byte received while busy starts nothing.
- R8: A byte of the form 0001 k xxx is a reset command. With k=0 it clears all settings to zero, aborts any scan and pulses the buffer-clear output. With k=1 it pulses buffer-clear only and keeps all settings.
- R9: A byte with bits 7:4 all zero changes no setting, starts no scan and pulses nothing.
- R10: After reset, busy, request, push and buffer-clear are low and both configuration outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock, oversampled by clk |
| spi_mosi | input | 1 | Serial command data |
| smp_req | output | 1 | Sample request, held until acknowledged |
| smp_chan | output | 4 | Channel of the requested sample |
| smp_ack | input | 1 | One-cycle sample acknowledge |
| smp_data | input | DATA_W | Sample value, valid with smp_ack |
| res_push | output | 1 | Result push strobe |
| res_data | output | DATA_W | Averaged result |
| res_chan | output | 4 | Channel of the pushed result |
| fifo_clr | output | 1 | One-cycle result-buffer clear |
| busy | output | 1 | Scan running |
| cfg_clk_mode | output | 2 | Stored clock-mode select |
| cfg_ref_sel | output | 2 | Stored reference select |

## Verification
Some properties are checked on every cycle. A serial byte completes at most once per edge group. Ignored bytes leave the settings alone, a full reset zeroes the settings, and a buffer-only reset keeps them. A conversion accepted with an external reference goes straight to sampling. A scan already running keeps its averaging parameters when another conversion byte arrives. The sample index never passes the averaging count. Other behaviour shows only across whole scenarios: the channel order of each scan mode, the averaged values and result counts, the exact wake-up gap and its persistence, dropping a partial byte, and aborting a scan mid-run. The bench shows these with a converter model whose sample values depend on channel and sample index.

// File: rtl/cmd_scan_pkg.sv
package cmd_scan_pkg;
  localparam int CMD_W   = 8;
  localparam int BCNT_W  = $clog2(CMD_W);
  localparam int CH_W    = 4;
  localparam int NCH     = 1 << CH_W;
  localparam int AVG_W   = 5;   // up to 32 samples per result
  localparam int SHIFT_W = 3;

  typedef enum logic [1:0] {
    SCAN_UP_TO  = 2'b00,
    SCAN_FROM   = 2'b01,
    SCAN_REPEAT = 2'b10,
    SCAN_SINGLE = 2'b11
  } scan_mode_t;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_WAKE   = 2'd1,
    SQ_SAMPLE = 2'd2,
    SQ_PUSH   = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic [1:0] clk_mode;
    logic [1:0] ref_sel;
    logic       avg_on;
    logic [1:0] navg;
    logic [1:0] nscan;
  } cfg_t;
endpackage

// File: rtl/cmd_shift.sv
module cmd_shift
  import cmd_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sclk,
  input  logic             spi_mosi,
  output logic             byte_vld,
  output logic [CMD_W-1:0] byte_data
);
  logic [1:0]        cs_q;
  logic [2:0]        sclk_q;
  logic [1:0]        mosi_q;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [CMD_W-1:0]  sh_q, sh_d;
  logic              vld_q, vld_d;
  logic              sclk_rise;

  assign sclk_rise = sclk_q[1] & ~sclk_q[2];

  always_comb begin
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    vld_d  = 1'b0;
    if (cs_q[1]) begin
      bcnt_d = '0;
    end else if (sclk_rise) begin
      sh_d   = {sh_q[CMD_W-2:0], mosi_q[1]};
      bcnt_d = bcnt_q + BCNT_W'(1);
      vld_d  = (bcnt_q == BCNT_W'(CMD_W-1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '1;
      sclk_q <= '0;
      mosi_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      cs_q   <= {cs_q[0], spi_cs_n};
      sclk_q <= {sclk_q[1:0], spi_sclk};
      mosi_q <= {mosi_q[0], spi_mosi};
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      vld_q  <= vld_d;
    end
  end

  assign byte_vld  = vld_q;
  assign byte_data = sh_q;

  AST_BYTE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld); // R1
endmodule

// File: rtl/cmd_regs.sv
module cmd_regs
  import cmd_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [CMD_W-1:0] byte_data,
  output cfg_t             cfg,
  output logic             setup_wr,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  output scan_mode_t       conv_mode,
  output logic             fifo_clr,
  output logic             full_clr
);
  cfg_t            cfg_q, cfg_d;
  logic            start_q, start_d;
  logic [CH_W-1:0] chan_q, chan_d;
  scan_mode_t      mode_q, mode_d;
  logic            setup_q, setup_d;
  logic            fclr_q, fclr_d;
  logic            full_q, full_d;

  always_comb begin
    cfg_d   = cfg_q;
    chan_d  = chan_q;
    mode_d  = mode_q;
    start_d = 1'b0;
    setup_d = 1'b0;
    fclr_d  = 1'b0;
    full_d  = 1'b0;
    if (byte_vld) begin
      if (byte_data[7]) begin
        start_d = 1'b1;
        chan_d  = byte_data[6:3];
        mode_d  = scan_mode_t'(byte_data[2:1]);
      end else if (byte_data[6]) begin
        cfg_d.clk_mode = byte_data[5:4];
        cfg_d.ref_sel  = byte_data[3:2];
        setup_d        = 1'b1;
      end else if (byte_data[5]) begin
        cfg_d.avg_on = byte_data[4];
        cfg_d.navg   = byte_data[3:2];
        cfg_d.nscan  = byte_data[1:0];
      end else if (byte_data[4]) begin
        fclr_d = 1'b1;
        if (!byte_data[3]) begin
          full_d = 1'b1;
          cfg_d  = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      chan_q  <= '0;
      mode_q  <= SCAN_UP_TO;
      start_q <= 1'b0;
      setup_q <= 1'b0;
      fclr_q  <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      chan_q  <= chan_d;
      mode_q  <= mode_d;
      start_q <= start_d;
      setup_q <= setup_d;
      fclr_q  <= fclr_d;
      full_q  <= full_d;
    end
  end

  assign cfg        = cfg_q;
  assign setup_wr   = setup_q;
  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign conv_mode  = mode_q;
  assign fifo_clr   = fclr_q;
  assign full_clr   = full_q;

  AST_FULL_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    full_clr |-> (cfg_q == '0)); // R8
  AST_FIFO_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr && !full_clr) |-> $stable(cfg_q)); // R8
  AST_NULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_data[7:4] == 4'b0000) |=> ($stable(cfg_q) && !start_q && !fclr_q)); // R9
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import cmd_scan_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int REF_WAKE = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   start_chan,
  input  scan_mode_t        start_mode,
  input  cfg_t              cfg,
  input  logic              setup_wr,
  input  logic              abort,
  output logic              smp_req,
  output logic [CH_W-1:0]   smp_chan,
  input  logic              smp_ack,
  input  logic [DATA_W-1:0] smp_data,
  output logic              res_push,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_chan,
  output logic              busy
);
  localparam int ACC_W = DATA_W + AVG_W;
  localparam int WK_W  = $clog2(REF_WAKE + 1);

  seq_state_t         state_q, state_d;
  logic [CH_W-1:0]    chan_q, chan_d;
  logic               step_q, step_d;
  logic [CH_W-1:0]    left_q, left_d;
  logic [AVG_W-1:0]   sidx_q, sidx_d;
  logic [AVG_W-1:0]   slast_q, slast_d;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic [ACC_W-1:0]   acc_q, acc_d;
  logic [WK_W-1:0]    wake_q, wake_d;
  logic               ref_on_q, ref_on_d;

  logic [CH_W-1:0]    first_chan, first_left;
  logic [AVG_W:0]     nsmp;
  logic               need_wake;

  always_comb begin
    case (start_mode)
      SCAN_UP_TO:  first_left = start_chan;
      SCAN_FROM:   first_left = CH_W'(NCH - 1) - start_chan;
      SCAN_REPEAT: first_left = CH_W'({cfg.nscan, 2'b11});
      default:     first_left = '0;
    endcase
    first_chan = (start_mode == SCAN_UP_TO) ? '0 : start_chan;
    nsmp       = (AVG_W+1)'(4) << cfg.navg;
    need_wake  = (cfg.ref_sel == 2'b00) || (cfg.ref_sel[1] && !ref_on_q);
  end

  always_comb begin
    state_d  = state_q;
    chan_d   = chan_q;
    step_d   = step_q;
    left_d   = left_q;
    sidx_d   = sidx_q;
    slast_d  = slast_q;
    shift_d  = shift_q;
    acc_d    = acc_q;
    wake_d   = wake_q;
    ref_on_d = ref_on_q;
    if (setup_wr) ref_on_d = 1'b0;
    case (state_q)
      SQ_IDLE: if (start) begin
        chan_d  = first_chan;
        step_d  = (start_mode == SCAN_UP_TO) || (start_mode == SCAN_FROM);
        left_d  = first_left;
        sidx_d  = '0;
        acc_d   = '0;
        wake_d  = '0;
        slast_d = cfg.avg_on ? AVG_W'(nsmp - (AVG_W+1)'(1)) : '0;
        shift_d = cfg.avg_on ? SHIFT_W'(3'd2 + {1'b0, cfg.navg}) : '0;
        state_d = need_wake ? SQ_WAKE : SQ_SAMPLE;
      end
      SQ_WAKE: begin
        if (wake_q == WK_W'(REF_WAKE - 1)) begin
          state_d = SQ_SAMPLE;
          if (cfg.ref_sel[1]) ref_on_d = 1'b1;
        end else begin
          wake_d = wake_q + WK_W'(1);
        end
      end
      SQ_SAMPLE: if (smp_ack) begin
        acc_d = acc_q + ACC_W'(smp_data);
        if (sidx_q == slast_q) state_d = SQ_PUSH;
        else                   sidx_d  = sidx_q + AVG_W'(1);
      end
      default: begin
        acc_d  = '0;
        sidx_d = '0;
        if (left_q == '0) begin
          state_d = SQ_IDLE;
        end else begin
          left_d  = left_q - CH_W'(1);
          chan_d  = chan_q + CH_W'(step_q);
          state_d = SQ_SAMPLE;
        end
      end
    endcase
    if (abort) begin
      state_d  = SQ_IDLE;
      ref_on_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      chan_q   <= '0;
      step_q   <= 1'b0;
      left_q   <= '0;
      sidx_q   <= '0;
      slast_q  <= '0;
      shift_q  <= '0;
      acc_q    <= '0;
      wake_q   <= '0;
      ref_on_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      chan_q   <= chan_d;
      step_q   <= step_d;
      left_q   <= left_d;
      sidx_q   <= sidx_d;
      slast_q  <= slast_d;
      shift_q  <= shift_d;
      acc_q    <= acc_d;
      wake_q   <= wake_d;
      ref_on_q <= ref_on_d;
    end
  end

  assign busy     = (state_q != SQ_IDLE);
  assign smp_req  = (state_q == SQ_SAMPLE);
  assign smp_chan = chan_q;
  assign res_push = (state_q == SQ_PUSH);
  assign res_chan = chan_q;
  assign res_data = DATA_W'(acc_q >> shift_q);

  AST_BUSY_KEEPS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !abort) |=> ($stable(slast_q) && $stable(shift_q) && $stable(step_q))); // R7
  AST_EXT_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !abort && cfg.ref_sel == 2'b01) |=> (state_q == SQ_SAMPLE)); // R6
  AST_PUSH_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    res_push |-> $past(smp_ack)); // R4
  AST_SIDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |-> (sidx_q <= slast_q)); // R4
endmodule

// File: rtl/cmd_scan_ctrl.sv
module cmd_scan_ctrl
  import cmd_scan_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int REF_WAKE = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              smp_req,
  output logic [3:0]        smp_chan,
  input  logic              smp_ack,
  input  logic [DATA_W-1:0] smp_data,
  output logic              res_push,
  output logic [DATA_W-1:0] res_data,
  output logic [3:0]        res_chan,
  output logic              fifo_clr,
  output logic              busy,
  output logic [1:0]        cfg_clk_mode,
  output logic [1:0]        cfg_ref_sel
);
  logic             byte_vld;
  logic [CMD_W-1:0] byte_data;
  cfg_t             cfg;
  logic             setup_wr, conv_start, full_clr;
  logic [CH_W-1:0]  conv_chan;
  scan_mode_t       conv_mode;

  cmd_shift i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .byte_vld  (byte_vld),
    .byte_data (byte_data)
  );

  cmd_regs i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .cfg        (cfg),
    .setup_wr   (setup_wr),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_mode  (conv_mode),
    .fifo_clr   (fifo_clr),
    .full_clr   (full_clr)
  );

  scan_seq #(.DATA_W(DATA_W), .REF_WAKE(REF_WAKE)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (conv_start),
    .start_chan (conv_chan),
    .start_mode (conv_mode),
    .cfg        (cfg),
    .setup_wr   (setup_wr),
    .abort      (full_clr),
    .smp_req    (smp_req),
    .smp_chan   (smp_chan),
    .smp_ack    (smp_ack),
    .smp_data   (smp_data),
    .res_push   (res_push),
    .res_data   (res_data),
    .res_chan   (res_chan),
    .busy       (busy)
  );

  assign cfg_clk_mode = cfg.clk_mode;
  assign cfg_ref_sel  = cfg.ref_sel;
endmodule

// File: tb/test_cmd_scan_ctrl.sv
module test_cmd_scan_ctrl;
  localparam int DATA_W   = 10;
  localparam int REF_WAKE = 40;
  localparam int NVEC     = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic smp_ack = 1'b0;
  logic [DATA_W-1:0] smp_data = '0;
  logic smp_req, res_push, fifo_clr, busy;
  logic [3:0] smp_chan, res_chan;
  logic [DATA_W-1:0] res_data;
  logic [1:0] cfg_clk_mode, cfg_ref_sel;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int k_smp = 0, n_res = 0, clr_cnt = 0, gap_cnt = 0, gap_val = -1;
  bit gap_done = 1'b0, busy_prev = 1'b0;
  int r_data [256];
  int r_chan [256];

  always #5 clk = ~clk;

  cmd_scan_ctrl #(.DATA_W(DATA_W), .REF_WAKE(REF_WAKE)) i_cmd_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .smp_req(smp_req), .smp_chan(smp_chan), .smp_ack(smp_ack), .smp_data(smp_data),
    .res_push(res_push), .res_data(res_data), .res_chan(res_chan), .fifo_clr(fifo_clr),
    .busy(busy), .cfg_clk_mode(cfg_clk_mode), .cfg_ref_sel(cfg_ref_sel));

  // converter model and result monitor: sample = chan*37 + index within result
  always @(negedge clk) begin
    if (res_push) begin
      if (n_res < 256) begin
        r_data[n_res] = int'(res_data);
        r_chan[n_res] = int'(res_chan);
      end
      n_res = n_res + 1;
      k_smp = 0;
    end
    if (!busy) k_smp = 0;
    if (fifo_clr) clr_cnt = clr_cnt + 1;
    if (smp_req && !smp_ack) begin
      smp_ack  = 1'b1;
      smp_data = DATA_W'(int'(smp_chan) * 37 + k_smp);
      k_smp    = k_smp + 1;
    end else begin
      smp_ack = 1'b0;
    end
    if (busy && !busy_prev) begin
      gap_cnt = 0;
      gap_done = 1'b0;
    end
    if (busy && !gap_done) begin
      if (smp_req) begin
        gap_val = gap_cnt;
        gap_done = 1'b1;
      end else begin
        gap_cnt = gap_cnt + 1;
      end
    end
    busy_prev = busy;
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    spi_cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 7; i > 7 - nb; i--) begin
      spi_mosi = b[i];
      repeat (3) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (3) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (3) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic wait_idle;
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // {averaging byte, conversion byte, result count, first chan, step, value offset}
  localparam logic [47:0] VECS [NVEC] = '{
    {8'h20, 8'hAE, 8'd1,  8'd5,  8'd0, 8'd0},   // single, avg off
    {8'h30, 8'h98, 8'd4,  8'd0,  8'd1, 8'd1},   // ch0..3, 4 samples
    {8'h34, 8'hEA, 8'd3,  8'd13, 8'd1, 8'd3},   // ch13..15, 8 samples
    {8'h39, 8'hBC, 8'd8,  8'd7,  8'd0, 8'd7},   // repeat x8, 16 samples
    {8'h3C, 8'hFF, 8'd1,  8'd15, 8'd0, 8'd15},  // single, 32 samples, bit0 set
    {8'h20, 8'hF8, 8'd16, 8'd0,  8'd1, 8'd0},   // ch0..15
    {8'h23, 8'h94, 8'd16, 8'd2,  8'd0, 8'd0}    // repeat x16
  };

  initial begin
    int base, bad_c, bad_d, c0, cl;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !smp_req && !res_push && !fifo_clr, "R10 idle outputs", int'({busy, smp_req, res_push, fifo_clr}), 0);
    chk(cfg_clk_mode == 2'b00 && cfg_ref_sel == 2'b00, "R10 cfg zero", int'({cfg_clk_mode, cfg_ref_sel}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && cfg_ref_sel == 2'b00, "R10 after release", int'({busy, cfg_ref_sel}), 0);

    // R2 setup decode (01_10_10_11)
    send_byte(8'h6B);
    chk(cfg_clk_mode == 2'b10, "R2 clock mode", int'(cfg_clk_mode), 2);
    chk(cfg_ref_sel == 2'b10, "R2 reference", int'(cfg_ref_sel), 2);

    // R1 partial byte dropped by chip select
    send_bits(8'hFF, 5);
    send_byte(8'h44);
    chk(cfg_clk_mode == 2'b00 && cfg_ref_sel == 2'b01, "R1 partial dropped", int'({cfg_clk_mode, cfg_ref_sel}), 1);
    chk(!busy && n_res == 0, "R1 no stray conversion", n_res, 0);

    // R3 R4 R5 table-driven scans with external reference
    for (int v = 0; v < NVEC; v++) begin
      send_byte(VECS[v][47:40]);
      base = n_res;
      send_byte(VECS[v][39:32]);
      wait_idle();
      chk(n_res - base == int'(VECS[v][31:24]), $sformatf("R5 count vec%0d", v), n_res - base, int'(VECS[v][31:24]));
      bad_c = 0; bad_d = 0;
      for (int i = 0; i < int'(VECS[v][31:24]) && base + i < 256; i++) begin
        c0 = int'(VECS[v][23:16]) + (VECS[v][0 +: 8] == 8'd0 ? 0 : 0) + (VECS[v][15:8] != 0 ? i : 0);
        if (r_chan[base + i] != c0) bad_c++;
        if (r_data[base + i] != c0 * 37 + int'(VECS[v][7:0])) bad_d++;
      end
      chk(bad_c == 0, $sformatf("R5 channel order vec%0d", v), bad_c, 0);
      chk(bad_d == 0, $sformatf("R4 R3 averaged value vec%0d", v), bad_d, 0);
    end

    // R6 wake-up handling
    send_byte(8'h20);
    chk(gap_val == 0, "R6 external no wait", gap_val, 0);
    send_byte(8'h40);
    send_byte(8'hAE); wait_idle();
    chk(gap_val == REF_WAKE, "R6 ref 00 first scan", gap_val, REF_WAKE);
    send_byte(8'hAE); wait_idle();
    chk(gap_val == REF_WAKE, "R6 ref 00 every scan", gap_val, REF_WAKE);
    send_byte(8'h48);
    send_byte(8'hAE); wait_idle();
    chk(gap_val == REF_WAKE, "R6 ref 10 first scan", gap_val, REF_WAKE);
    send_byte(8'hAE); wait_idle();
    chk(gap_val == 0, "R6 ref 10 stays on", gap_val, 0);
    send_byte(8'h44);
    send_byte(8'hAE); wait_idle();
    chk(gap_val == 0, "R6 external", gap_val, 0);

    // R7 conversion while busy ignored
    send_byte(8'h3F);
    base = n_res;
    send_byte(8'hCC);
    chk(busy == 1'b1, "R7 busy during scan", int'(busy), 1);
    send_byte(8'hAE);
    wait_idle();
    chk(n_res - base == 16, "R7 extra conversion dropped", n_res - base, 16);
    bad_d = 0;
    for (int i = base; i < n_res && i < 256; i++)
      if (r_chan[i] != 9 || r_data[i] != 9 * 37 + 15) bad_d++;
    chk(bad_d == 0, "R7 results from first scan only", bad_d, 0);
    chk(!busy, "R7 busy low after last push", int'(busy), 0);

    // R9 null byte
    send_byte(8'h6B);
    cl = clr_cnt; base = n_res;
    send_byte(8'h07);
    chk(cfg_clk_mode == 2'b10 && cfg_ref_sel == 2'b10, "R9 cfg kept", int'({cfg_clk_mode, cfg_ref_sel}), 10);
    chk(clr_cnt == cl && !busy && n_res == base, "R9 nothing pulsed", clr_cnt - cl, 0);

    // R8 buffer-only reset
    send_byte(8'h18);
    chk(clr_cnt == cl + 1, "R8 buffer clear pulse", clr_cnt - cl, 1);
    chk(cfg_clk_mode == 2'b10 && cfg_ref_sel == 2'b10, "R8 cfg kept", int'({cfg_clk_mode, cfg_ref_sel}), 10);

    // R8 full reset aborting a scan
    send_byte(8'h44);
    send_byte(8'h3F);
    send_byte(8'hCC);
    repeat (100) @(negedge clk);
    chk(busy == 1'b1, "R8 scan running", int'(busy), 1);
    send_byte(8'h10);
    chk(!busy, "R8 scan aborted", int'(busy), 0);
    chk(clr_cnt == cl + 2, "R8 full reset clear pulse", clr_cnt - cl, 2);
    chk(cfg_clk_mode == 2'b00 && cfg_ref_sel == 2'b00, "R8 cfg zeroed", int'({cfg_clk_mode, cfg_ref_sel}), 0);
    // averaging cleared: single conversion now returns raw sample
    base = n_res;
    send_byte(8'hAE); wait_idle();
    chk(n_res - base == 1 && r_data[base] == 5 * 37, "R8 averaging cleared", r_data[base], 5 * 37);

    finish_run();
  end
endmodule